// File: doc/BRIEF.md
# Global-History Indirect Target Predictor

This block sits beside a branch target array and refines the target predicted for indirect branches. It keeps a small tagged table of targets keyed by the path leading to a branch: the global history and the branch address are XOR-folded together. The low bits of the result select an entry and the high bits form a partial tag. When the target array marks the fetched branch as indirect and the table holds a matching entry, the stored target replaces the target array's target. In every other case the target array's target passes through unchanged.

The table learns only from target mispredictions. A branch whose indirect target never changes is always predicted correctly by the target array, so it never takes an entry here. A branch whose target depends on data takes one entry for each distinct history seen at a misprediction. Lookups pass through two register stages: a synchronous table read, then a registered compare-and-select. The table itself is written in a form suited to block RAM.

Top module: `ind_target_pred`

## Requirements
- R1: While reset is asserted and after reset is released, no entry is valid. Every lookup reports `pred_hit`=0 and passes `lk_ta_target` through. During reset both outputs read 0.
- R2: The key is key[15:0] = addr[15:0] ^ addr[31:16] ^ hist[15:0]. The entry index is key[7:0] and the tag is key[15:8], so two (address, history) pairs with the same key share an entry.
- R3: `pred_target` takes the table target only when `lk_indirect` is 1 and the indexed entry is valid with a matching tag. Otherwise it equals `lk_ta_target`, and `pred_hit` reports whether the table target was used.
- R4: An update with `up_valid`=1 and `up_mispredict`=1 writes the entry at the update key's index with the update key's tag and `up_target`, and marks it valid.
- R5: An update with `up_valid`=0, or with `up_mispredict`=0, changes no entry.
- R6: A valid entry whose tag differs from the lookup tag at the same index gives a miss.
- R7: One branch address seen with different histories can hold separate entries with different targets.
- R8: A lookup in the same cycle as a write to the same index sees the entry's contents from before the write.
- R9: `pred_hit` and `pred_target` show the result of a lookup two clock edges after the lookup inputs are sampled, and a new lookup can start every cycle.
- R10: A write to an index that already holds a valid entry replaces it, and lookups matching the old tag then miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_addr | input | 32 | Address of the branch being looked up |
| lk_hist | input | 16 | Global history at lookup |
| lk_indirect | input | 1 | Target array marks the branch as indirect |
| lk_ta_target | input | 32 | Target predicted by the target array |
| pred_target | output | 32 | Final predicted target (registered) |
| pred_hit | output | 1 | The table target was used (registered) |
| up_valid | input | 1 | An update is presented |
| up_addr | input | 32 | Address of the resolved branch |
| up_hist | input | 16 | Global history seen by the resolved branch |
| up_target | input | 32 | Actual target of the resolved branch |
| up_mispredict | input | 1 | The target of the resolved branch was mispredicted |

## Verification
Each lookup's outputs are due at the second rising edge after its inputs are driven. A table write takes effect at the edge where it is sampled, so it is visible only to lookups driven in later cycles. The driver applies a lookup in every cycle. For each lookup it records the expected hit and target, taken from a bench model as it stands before that cycle's write, together with the cycle in which the result is due. The monitor compares at the falling edge of exactly that cycle, so a result that arrives one cycle early or late is reported.

// File: rtl/itp_pkg.sv
package itp_pkg;
  parameter int unsigned DEF_ADDR_W = 32;
  parameter int unsigned DEF_HIST_W = 16;
  parameter int unsigned DEF_IDX_W  = 8;
  parameter int unsigned DEF_TAG_W  = 8;
  parameter int unsigned DEF_TGT_W  = 32;
endpackage

// File: rtl/itp_hash.sv
module itp_hash #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned HIST_W = 16,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned TAG_W  = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [HIST_W-1:0] hist,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag
);
  localparam int unsigned KEY_W = IDX_W + TAG_W;

  logic [KEY_W-1:0] key;

  // fold every address and history bit onto the key
  always_comb begin
    key = '0;
    for (int i = 0; i < ADDR_W; i++) key[i % KEY_W] = key[i % KEY_W] ^ addr[i];
    for (int j = 0; j < HIST_W; j++) key[j % KEY_W] = key[j % KEY_W] ^ hist[j];
  end

  assign idx = key[IDX_W-1:0];
  assign tag = key[KEY_W-1:IDX_W];
endmodule

// File: rtl/itp_table.sv
module itp_table #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned TAG_W = 8,
  parameter int unsigned TGT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [TGT_W-1:0] wr_tgt,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic [TGT_W-1:0] rd_tgt
);
  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam int unsigned ENT_W = TAG_W + TGT_W;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [ENT_W-1:0] rd_q;
  logic [DEPTH-1:0] vld;

  // payload: no reset, read-first, suited to block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= {wr_tag, wr_tgt};
    rd_q <= mem[rd_idx];
  end

  // valid bits in flops so reset can clear them
  always_ff @(posedge clk) begin
    if (rst) begin
      vld      <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_en) vld[wr_idx] <= 1'b1;
      rd_valid <= vld[rd_idx];
    end
  end

  assign rd_tag = rd_q[ENT_W-1:TGT_W];
  assign rd_tgt = rd_q[TGT_W-1:0];

  // R4
  alloc_valid_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> vld[$past(wr_idx)]);
  // R5
  no_write_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(vld));
  // R8
  read_old_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == rd_idx && !vld[rd_idx]) |=> !rd_valid);
endmodule

// File: rtl/itp_select.sv
module itp_select #(
  parameter int unsigned TAG_W = 8,
  parameter int unsigned TGT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ent_valid,
  input  logic [TAG_W-1:0] ent_tag,
  input  logic [TGT_W-1:0] ent_tgt,
  input  logic [TAG_W-1:0] want_tag,
  input  logic             indirect,
  input  logic [TGT_W-1:0] ta_tgt,
  output logic             hit,
  output logic [TGT_W-1:0] tgt
);
  logic use_tab;

  assign use_tab = indirect && ent_valid && (ent_tag == want_tag);

  always_ff @(posedge clk) begin
    if (rst) begin
      hit <= 1'b0;
      tgt <= '0;
    end else begin
      hit <= use_tab;
      tgt <= use_tab ? ent_tgt : ta_tgt;
    end
  end
endmodule

// File: rtl/ind_target_pred.sv
module ind_target_pred
  import itp_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned HIST_W = DEF_HIST_W,
  parameter int unsigned IDX_W  = DEF_IDX_W,
  parameter int unsigned TAG_W  = DEF_TAG_W,
  parameter int unsigned TGT_W  = DEF_TGT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic [HIST_W-1:0] lk_hist,
  input  logic              lk_indirect,
  input  logic [TGT_W-1:0]  lk_ta_target,
  output logic [TGT_W-1:0]  pred_target,
  output logic              pred_hit,
  input  logic              up_valid,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [HIST_W-1:0] up_hist,
  input  logic [TGT_W-1:0]  up_target,
  input  logic              up_mispredict
);
  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic             wr_en;
  logic             ent_valid;
  logic [TAG_W-1:0] ent_tag;
  logic [TGT_W-1:0] ent_tgt;
  logic [TAG_W-1:0] s1_tag;
  logic             s1_ind;
  logic [TGT_W-1:0] s1_ta;
  logic [1:0]       age;

  itp_hash #(.ADDR_W(ADDR_W), .HIST_W(HIST_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_lk_hash (
    .addr(lk_addr), .hist(lk_hist), .idx(lk_idx), .tag(lk_tag));

  itp_hash #(.ADDR_W(ADDR_W), .HIST_W(HIST_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_up_hash (
    .addr(up_addr), .hist(up_hist), .idx(up_idx), .tag(up_tag));

  assign wr_en = up_valid && up_mispredict;

  itp_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(TGT_W)) u_table (
    .clk(clk), .rst(rst), .rd_idx(lk_idx),
    .wr_en(wr_en), .wr_idx(up_idx), .wr_tag(up_tag), .wr_tgt(up_target),
    .rd_valid(ent_valid), .rd_tag(ent_tag), .rd_tgt(ent_tgt));

  // stage 1: carry lookup side-band alongside the table read
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_tag <= '0;
      s1_ind <= 1'b0;
      s1_ta  <= '0;
    end else begin
      s1_tag <= lk_tag;
      s1_ind <= lk_indirect;
      s1_ta  <= lk_ta_target;
    end
  end

  itp_select #(.TAG_W(TAG_W), .TGT_W(TGT_W)) u_select (
    .clk(clk), .rst(rst),
    .ent_valid(ent_valid), .ent_tag(ent_tag), .ent_tgt(ent_tgt),
    .want_tag(s1_tag), .indirect(s1_ind), .ta_tgt(s1_ta),
    .hit(pred_hit), .tgt(pred_target));

  // edges since reset, only to qualify the two-deep checks below
  always_ff @(posedge clk) begin
    if (rst) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R3
  hit_needs_indirect_chk: assert property (@(posedge clk) disable iff (rst)
    (age[1] && pred_hit) |-> $past(lk_indirect, 2));
  // R3
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    (age[1] && !pred_hit) |-> pred_target == $past(lk_ta_target, 2));
  // R1
  fresh_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd3) |-> !pred_hit);
endmodule

// File: tb/tb_ind_target_pred.sv
module tb_ind_target_pred;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lk_addr = '0;
  logic [15:0] lk_hist = '0;
  logic        lk_indirect = 1'b0;
  logic [31:0] lk_ta_target = '0;
  logic [31:0] pred_target;
  logic        pred_hit;
  logic        up_valid = 1'b0;
  logic [31:0] up_addr = '0;
  logic [15:0] up_hist = '0;
  logic [31:0] up_target = '0;
  logic        up_mispredict = 1'b0;

  always #4 clk = ~clk;

  ind_target_pred dut (
    .clk(clk), .rst(rst), .lk_addr(lk_addr), .lk_hist(lk_hist),
    .lk_indirect(lk_indirect), .lk_ta_target(lk_ta_target),
    .pred_target(pred_target), .pred_hit(pred_hit),
    .up_valid(up_valid), .up_addr(up_addr), .up_hist(up_hist),
    .up_target(up_target), .up_mispredict(up_mispredict));

  typedef struct {
    int          due;
    logic        hit;
    logic [31:0] tgt;
    string       req;
  } exp_t;

  exp_t        sbq[$];
  exp_t        cur;
  int          cyc = 0;
  int          n_run = 0;
  int          n_fail = 0;
  logic        m_vld [256];
  logic [7:0]  m_tag [256];
  logic [31:0] m_tgt [256];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] key_of(input logic [31:0] a, input logic [15:0] h);
    return a[15:0] ^ a[31:16] ^ h;   // R2
  endfunction

  // monitor: compare each result exactly in its due cycle
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      cur = sbq.pop_front();
      n_run++;
      if (cur.due != cyc || pred_hit !== cur.hit || pred_target !== cur.tgt) begin
        n_fail++;
        $display("FAIL %s R9: cyc %0d hit=%0b tgt=%h expected hit=%0b tgt=%h",
                 cur.req, cyc, pred_hit, pred_target, cur.hit, cur.tgt);
      end
    end
  end

  task automatic step(input logic [31:0] la, input logic [15:0] lh, input logic li,
                      input logic [31:0] lt, input logic uv, input logic um,
                      input logic [31:0] ua, input logic [15:0] uh,
                      input logic [31:0] ut, input string req);
    exp_t e;
    logic [15:0] k;
    @(negedge clk); #1;
    k = key_of(la, lh);
    e.due = cyc + 2;
    e.hit = li && m_vld[k[7:0]] && (m_tag[k[7:0]] == k[15:8]);
    e.tgt = e.hit ? m_tgt[k[7:0]] : lt;
    e.req = req;
    sbq.push_back(e);
    lk_addr = la; lk_hist = lh; lk_indirect = li; lk_ta_target = lt;
    up_valid = uv; up_mispredict = um; up_addr = ua; up_hist = uh; up_target = ut;
    if (uv && um) begin
      k = key_of(ua, uh);
      m_vld[k[7:0]] = 1'b1;
      m_tag[k[7:0]] = k[15:8];
      m_tgt[k[7:0]] = ut;
    end
  endtask

  task automatic look(input logic [31:0] la, input logic [15:0] lh, input logic li,
                      input logic [31:0] lt, input string req);
    step(la, lh, li, lt, 1'b0, 1'b0, '0, '0, '0, req);
  endtask

  task automatic upd(input logic um, input logic [31:0] ua, input logic [15:0] uh,
                     input logic [31:0] ut, input string req);
    step(32'h0, 16'h0, 1'b0, 32'hAAAA_0000, 1'b1, um, ua, uh, ut, req);
  endtask

  localparam logic [31:0] A  = 32'h0040_1234;
  localparam logic [15:0] H1 = 16'h00F0;
  localparam logic [15:0] H2 = 16'h0F0F;

  initial begin
    for (int i = 0; i < 256; i++) begin m_vld[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; end
    repeat (3) @(negedge clk);
    n_run++;  // R1 reset state
    if (pred_hit !== 1'b0 || pred_target !== 32'h0) begin
      n_fail++;
      $display("FAIL R1: in reset hit=%0b tgt=%h expected hit=0 tgt=00000000", pred_hit, pred_target);
    end
    rst = 1'b0;
    look(A, H1, 1'b1, 32'h1111_0000, "R1");
    look(32'hDEAD_BEEF, 16'h1234, 1'b1, 32'h1111_0001, "R1");
    // R5: no allocation without mispredict, or without update valid
    upd(1'b0, A, H1, 32'hBAD0_0001, "R5");
    step(A, H1, 1'b1, 32'h2222_0000, 1'b0, 1'b1, A, H1, 32'hBAD0_0002, "R5");
    look(A, H1, 1'b1, 32'h2222_0001, "R5");
    // R4: allocate on mispredict
    upd(1'b1, A, H1, 32'hC0DE_0001, "R4");
    look(A, H1, 1'b1, 32'h3333_0000, "R4");
    // R3: not indirect -> pass through even on a matching entry
    look(A, H1, 1'b0, 32'h3333_0001, "R3");
    // R2: different pair with the same folded key shares the entry
    look(32'h0040_1334, H1 ^ 16'h0100, 1'b1, 32'h3333_0002, "R2");
    // R6: same index, other tag
    look(A, H1 ^ 16'h0100, 1'b1, 32'h3333_0003, "R6");
    // R7: second history, second target for the same branch
    upd(1'b1, A, H2, 32'hC0DE_0002, "R7");
    look(A, H2, 1'b1, 32'h4444_0000, "R7");
    look(A, H1, 1'b1, 32'h4444_0001, "R7");
    // R5: non-mispredict update does not disturb an existing entry
    upd(1'b0, A, H1, 32'hBAD0_0003, "R5");
    look(A, H1, 1'b1, 32'h4444_0002, "R5");
    // R8: write and read of the same index in one cycle
    step(32'h0000_5555, 16'h0, 1'b1, 32'h5555_0000, 1'b1, 1'b1,
         32'h0000_5555, 16'h0, 32'hC0DE_0003, "R8");
    look(32'h0000_5555, 16'h0, 1'b1, 32'h5555_0001, "R8");
    // R8: same-cycle overwrite of a valid entry sees old target
    step(32'h0000_5555, 16'h0, 1'b1, 32'h5555_0002, 1'b1, 1'b1,
         32'h0000_5555, 16'h0, 32'hC0DE_0004, "R8");
    look(32'h0000_5555, 16'h0, 1'b1, 32'h5555_0003, "R8");
    // R10: replace entry at index of (A,H1) with a different tag
    upd(1'b1, A, H1 ^ 16'h0100, 32'hC0DE_0005, "R10");
    look(A, H1, 1'b1, 32'h6666_0000, "R10");
    look(A, H1 ^ 16'h0100, 1'b1, 32'h6666_0001, "R10");
    // mixed traffic over a small address/history set
    for (int n = 0; n < 300; n++) begin
      step({24'h0040_12, 4'h0, 4'($urandom_range(0, 3))}, 16'($urandom_range(0, 7)),
           1'($urandom_range(0, 1)), $urandom(),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           {24'h0040_12, 4'h0, 4'($urandom_range(0, 3))}, 16'($urandom_range(0, 7)),
           $urandom(), "R4");
    end
    look(32'h0, 16'h0, 1'b0, 32'h0, "R3");
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule